// File: doc/BRIEF.md
# Priority-Level Interrupt Arbiter

This block gathers interrupt requests from a parameterised set of devices (eight by default). Each device has a ready flag, an enable flag and a 3-bit urgency level, where level 7 is the most urgent. A device requests service only while both its ready flag and its enable flag are high. Among the requesting devices, the block picks the one with the highest level. It then compares that level with the level of the program the processor is running. The interrupt line goes high only when the winner's level is strictly greater than the running level. A request at the same level, or at a lower one, never interrupts.

The processor checks the interrupt line only at an instruction boundary, and it marks that moment with a one-cycle strobe. When the strobe arrives while the interrupt line is high, the block stores the winning device index and its level in service registers. The processor reads these to locate the handler. The stored values stay unchanged until the processor pulses acknowledge. When two requests share the same top level, the lower device index wins.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, `irq`, `svc_valid`, `svc_idx` and `svc_lvl` are all zero.
- R2: Device i requests only when `dev_ready[i]` and `dev_ie[i]` are both 1. A device with only one of the two flags high does not affect `irq` or the captured winner.
- R3: Among the requesting devices, the winner is the one with the highest level. Device i's level is `dev_level[3*i+2:3*i]`.
- R4: When several requesting devices share the highest level, the one with the lowest index wins.
- R5: `irq` is 1 one clock after the inputs present a winner whose level is strictly greater than `cpu_level`.
- R6: `irq` is 0 one clock after the inputs present no request, or a winner whose level is equal to or below `cpu_level`.
- R7: A `boundary` pulse while `irq` is 1 and `svc_valid` is 0 sets `svc_valid` on the next clock. It also loads the winner's index into `svc_idx` and its level into `svc_lvl`. A `boundary` pulse while `irq` is 0 leaves `svc_valid` at 0.
- R8: While `svc_valid` is 1 and `ack` is 0, `svc_idx` and `svc_lvl` hold their values. This holds even if requests change or further `boundary` pulses arrive.
- R9: `ack` while `svc_valid` is 1 clears `svc_valid` on the next clock. A later `boundary` pulse can then capture a new winner.
- R10: `irq` follows changes to `cpu_level` on every clock, with the one-clock latency of R5 and R6. The same request can therefore raise or drop `irq` as the running level moves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_ready | input | N | Per-device ready flag |
| dev_ie | input | N | Per-device interrupt enable |
| dev_level | input | 3*N | Packed per-device urgency levels, device i in bits 3i+2..3i |
| cpu_level | input | 3 | Level of the program now running |
| boundary | input | 1 | One-cycle instruction-boundary strobe |
| ack | input | 1 | Service acknowledge pulse |
| irq | output | 1 | Registered interrupt request to the processor |
| svc_valid | output | 1 | Captured winner is held |
| svc_idx | output | log2(N) | Captured device index |
| svc_lvl | output | 3 | Captured device level |

## Verification
The assertions check the capture handshake on every cycle:
- A boundary pulse with `irq` high sets `svc_valid`, and without `irq` it leaves `svc_valid` clear.
- The held index and level stay stable until acknowledge, and acknowledge clears `svc_valid`.
- Every captured level is strictly above the running level that was compared.
- `irq` is never high unless some device had both of its flags set.

Which device wins, the tie order, the rejection at an equal level, and the way `irq` follows a moving `cpu_level` depend on specific level patterns. The bench's directed scenarios show these behaviours by comparing against values worked out by hand.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
  parameter int N = 8
) (
  input  logic [N-1:0] ready,
  input  logic [N-1:0] ie,
  output logic [N-1:0] req
);
  for (genvar g = 0; g < N; g++) begin : g_gate
    assign req[g] = ready[g] & ie[g];
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_arb_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       req,
  input  logic [N*LVL_W-1:0] levels,
  output logic               any,
  output logic [IDX_W-1:0]   win_idx,
  output lvl_t               win_lvl
);
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    // ascending scan with strict compare keeps the lower index on ties
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!any || (levels[i*LVL_W +: LVL_W] > win_lvl))) begin
        any     = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = levels[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_lvl_cmp.sv
module irq_lvl_cmp
  import irq_arb_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any,
  input  logic [IDX_W-1:0] win_idx,
  input  lvl_t             win_lvl,
  input  lvl_t             cpu_level,
  output logic             irq_q,
  output logic [IDX_W-1:0] idx_q,
  output lvl_t             lvl_q
);
  logic outranks;
  assign outranks = any && (win_lvl > cpu_level);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      idx_q <= '0;
      lvl_q <= '0;
    end else begin
      irq_q <= outranks;
      idx_q <= win_idx;
      lvl_q <= win_lvl;
    end
  end
endmodule

// File: rtl/irq_svc_latch.sv
module irq_svc_latch
  import irq_arb_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boundary,
  input  logic             ack,
  input  logic             irq,
  input  logic [IDX_W-1:0] idx_in,
  input  lvl_t             lvl_in,
  output logic             held,
  output logic [IDX_W-1:0] idx_out,
  output lvl_t             lvl_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= 1'b0;
      idx_out <= '0;
      lvl_out <= '0;
    end else if (held) begin
      if (ack) held <= 1'b0;
    end else if (boundary && irq) begin
      held    <= 1'b1;
      idx_out <= idx_in;
      lvl_out <= lvl_in;
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       dev_ready,
  input  logic [N-1:0]       dev_ie,
  input  logic [N*LVL_W-1:0] dev_level,
  input  logic [LVL_W-1:0]   cpu_level,
  input  logic               boundary,
  input  logic               ack,
  output logic               irq,
  output logic               svc_valid,
  output logic [IDX_W-1:0]   svc_idx,
  output logic [LVL_W-1:0]   svc_lvl
);
  logic [N-1:0]     req;
  logic             any;
  logic [IDX_W-1:0] win_idx, idx_q;
  lvl_t             win_lvl, lvl_q;

  irq_req_gate #(.N(N)) u_gate (
    .ready(dev_ready), .ie(dev_ie), .req(req)
  );

  irq_prio_enc #(.N(N), .IDX_W(IDX_W)) u_enc (
    .req(req), .levels(dev_level), .any(any),
    .win_idx(win_idx), .win_lvl(win_lvl)
  );

  irq_lvl_cmp #(.IDX_W(IDX_W)) u_cmp (
    .clk(clk), .rst(rst), .any(any), .win_idx(win_idx), .win_lvl(win_lvl),
    .cpu_level(cpu_level), .irq_q(irq), .idx_q(idx_q), .lvl_q(lvl_q)
  );

  irq_svc_latch #(.IDX_W(IDX_W)) u_latch (
    .clk(clk), .rst(rst), .boundary(boundary), .ack(ack), .irq(irq),
    .idx_in(idx_q), .lvl_in(lvl_q),
    .held(svc_valid), .idx_out(svc_idx), .lvl_out(svc_lvl)
  );
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
  parameter int N     = 8,
  parameter int LVL_W = 3,
  parameter int IDX_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [N-1:0]       dev_ready,
  input logic [N-1:0]       dev_ie,
  input logic [LVL_W-1:0]   cpu_level,
  input logic               boundary,
  input logic               ack,
  input logic               irq,
  input logic               svc_valid,
  input logic [IDX_W-1:0]   svc_idx,
  input logic [LVL_W-1:0]   svc_lvl
);
  assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(dev_ready & dev_ie)));

  assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (!svc_valid && boundary && irq) |=> svc_valid);

  assert_no_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (!svc_valid && !(boundary && irq)) |=> !svc_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (svc_valid && !ack) |=> (svc_valid && $stable(svc_idx) && $stable(svc_lvl)));

  assert_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (svc_valid && ack) |=> !svc_valid);

  assert_outranks_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(svc_valid) |-> (svc_lvl > $past(cpu_level, 2)));
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.N(N), .LVL_W(irq_arb_pkg::LVL_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .dev_ready(dev_ready), .dev_ie(dev_ie),
  .cpu_level(cpu_level), .boundary(boundary), .ack(ack), .irq(irq),
  .svc_valid(svc_valid), .svc_idx(svc_idx), .svc_lvl(svc_lvl)
);

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]   dev_ready = '0;
  logic [N-1:0]   dev_ie = '0;
  logic [N*3-1:0] dev_level = '0;
  logic [2:0]     cpu_level = '0;
  logic boundary = 1'b0;
  logic ack = 1'b0;
  logic irq, svc_valid;
  logic [2:0] svc_idx, svc_lvl;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_prio_arbiter u_irq_prio_arbiter (
    .clk(clk), .rst(rst), .dev_ready(dev_ready), .dev_ie(dev_ie),
    .dev_level(dev_level), .cpu_level(cpu_level), .boundary(boundary),
    .ack(ack), .irq(irq), .svc_valid(svc_valid), .svc_idx(svc_idx),
    .svc_lvl(svc_lvl)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_lvl(int dev, int l);
    dev_level[dev*3 +: 3] = 3'(l);
  endtask

  // inputs applied at negedge; registered irq is visible at the next negedge
  task automatic settle();
    @(negedge clk);
  endtask

  task automatic strobe();
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic clear_all();
    dev_ready = '0; dev_ie = '0; dev_level = '0; cpu_level = '0;
  endtask

  task automatic t_reset();
    chk("R1 irq", irq, 0);
    chk("R1 svc_valid", svc_valid, 0);
    chk("R1 svc_idx", svc_idx, 0);
    chk("R1 svc_lvl", svc_lvl, 0);
  endtask

  task automatic t_gate();
    clear_all();
    for (int i = 0; i < N; i++) set_lvl(i, 5);
    dev_ready = '1; dev_ie = '0;
    settle();
    chk("R2 ready only", irq, 0);
    dev_ready = '0; dev_ie = '1;
    settle();
    chk("R2 enable only", irq, 0);
    // dev0 level 7 ready only, dev5 level 2 fully requesting, cpu 1
    clear_all();
    set_lvl(0, 7); set_lvl(5, 2);
    dev_ready = 8'b0010_0001; dev_ie = 8'b0010_0000; cpu_level = 3'd1;
    settle();
    chk("R2 irq from dev5", irq, 1);
    strobe();
    chk("R2 idx", svc_idx, 5);
    chk("R2 lvl", svc_lvl, 2);
    do_ack();
  endtask

  task automatic t_highest();
    clear_all();
    set_lvl(0, 1); set_lvl(3, 6); set_lvl(5, 4);
    dev_ready = 8'b0010_1001; dev_ie = 8'b0010_1001;
    settle();
    chk("R5 irq", irq, 1);
    strobe();
    chk("R7 svc_valid", svc_valid, 1);
    chk("R3 idx", svc_idx, 3);
    chk("R3 lvl", svc_lvl, 6);
    do_ack();
    chk("R9 cleared", svc_valid, 0);
  endtask

  task automatic t_tie();
    clear_all();
    set_lvl(1, 3); set_lvl(2, 5); set_lvl(6, 5);
    dev_ready = 8'b0100_0110; dev_ie = 8'b0100_0110;
    settle();
    strobe();
    chk("R4 idx", svc_idx, 2);
    chk("R4 lvl", svc_lvl, 5);
    do_ack();
  endtask

  task automatic t_equal();
    clear_all();
    set_lvl(4, 3);
    dev_ready = 8'b0001_0000; dev_ie = 8'b0001_0000; cpu_level = 3'd3;
    settle();
    chk("R6 equal level", irq, 0);
    cpu_level = 3'd2;
    settle();
    chk("R10 cpu lowered", irq, 1);
    cpu_level = 3'd7;
    settle();
    chk("R10 cpu raised", irq, 0);
    strobe();
    chk("R7 no capture", svc_valid, 0);
    dev_ready = '0;
    cpu_level = 3'd0;
    settle();
    chk("R6 no request", irq, 0);
  endtask

  task automatic t_hold();
    clear_all();
    set_lvl(7, 7);
    dev_ready = 8'b1000_0000; dev_ie = 8'b1000_0000;
    settle();
    strobe();
    chk("R7 captured", svc_valid, 1);
    clear_all();
    set_lvl(1, 2);
    dev_ready = 8'b0000_0010; dev_ie = 8'b0000_0010;
    settle();
    strobe();
    chk("R8 still valid", svc_valid, 1);
    chk("R8 idx held", svc_idx, 7);
    chk("R8 lvl held", svc_lvl, 7);
    do_ack();
    chk("R9 ack clears", svc_valid, 0);
    strobe();
    chk("R9 recapture valid", svc_valid, 1);
    chk("R9 recapture idx", svc_idx, 1);
    chk("R9 recapture lvl", svc_lvl, 2);
    do_ack();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gate();
    t_highest();
    t_tie();
    t_equal();
    t_hold();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule